// File: doc/BRIEF.md
# Criticality-Driven Line Placement Predictor

This block picks the destination bank for a line being filled into a data cache that is split into a fast bank (hot) and a slow, low-energy bank (cold). While a line is resident, every access to its slot is tagged critical or non-critical by the core, and a small saturating up/down counter for that slot follows the balance between the two kinds. When the line leaves the cache, its counter is reduced to one bit (critical or not). That bit is stored in a direct-mapped bit table indexed by a fold of the block address.

When the same block is fetched again, the fill request reads the table, and the response tells the cache which bank to write. The placement therefore follows the line's behaviour during its previous stay in the cache. Table entries start at 1 after reset, so blocks that have never been seen go to the hot bank.

Requests arrive on three independent ports (access, eviction, fill), and any mix of them may appear in one cycle. Eviction and fill each return a registered response one cycle later. The cache arrays, the tags and the next cache level are outside this block.

Top module: `crit_place_predictor`

## Requirements
- R1: After reset, and whenever a slot receives a fill, that slot's counter holds the midpoint value 8.
- R2: An access with `acc_crit`=1 raises the addressed slot's counter by one, and an access with `acc_crit`=0 lowers it by one.
- R3: The counter saturates. A critical access at 15 leaves it at 15, and a non-critical access at 0 leaves it at 0.
- R4: An eviction reports `evict_rsp_crit`=1 one cycle later when the slot's counter is 8 or more, and 0 otherwise.
- R5: An eviction writes its critical bit into the table entry at the eviction address's index. A fill returns that entry one cycle later on `fill_rsp_hot`, where 1 means hot bank and 0 means cold bank.
- R6: After reset, every table entry reads 1.
- R7: The table index is the XOR of the consecutive 12-bit chunks of the 26-bit block address, taken from bit 0 upward, with the top chunk zero-padded. Addresses with equal folds share one entry.
- R8: When an eviction and a fill hit the same table index in one cycle, the write happens first and the fill returns the newly written bit.
- R9: When an access and a fill target the same slot in one cycle, the access applies to the new line: its counter becomes 8 stepped by that access.
- R10: When an access and an eviction target the same slot in one cycle, and no fill targets that slot, the access is counted before the line is classified. An eviction that shares its slot with a fill classifies the old counter.
- R11: `fill_rsp_valid` and `evict_rsp_valid` are high exactly in the cycle after a fill or an eviction request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access to a resident line this cycle |
| acc_slot | input | 9 | Cache slot being accessed |
| acc_crit | input | 1 | 1 when the accessing instruction is critical |
| evict_valid | input | 1 | A line is leaving the cache this cycle |
| evict_slot | input | 9 | Slot of the departing line |
| evict_addr | input | 26 | Block address of the departing line |
| fill_valid | input | 1 | A line is being fetched into the cache this cycle |
| fill_slot | input | 9 | Slot that receives the new line |
| fill_addr | input | 26 | Block address of the new line |
| evict_rsp_valid | output | 1 | Eviction classification is valid |
| evict_rsp_crit | output | 1 | Classification of the departed line |
| fill_rsp_valid | output | 1 | Placement decision is valid |
| fill_rsp_hot | output | 1 | 1 = place in hot bank, 0 = cold bank |

## Verification
An eviction and a fill can land in the same cycle on the same table index, and this is also where the counter and the table interact most closely. A directed case drops a line's counter below threshold and then evicts and refills that same address in one cycle. The fill must return the freshly written 0 rather than the stale 1. The random phase draws addresses from a small pool that includes aliases of equal fold, so this collision and the slot collisions of R9 and R10 recur many times, and every response is compared with a reference model in the bench.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

    typedef enum logic {
        BANK_COLD = 1'b0,
        BANK_HOT  = 1'b1
    } bank_e;

    localparam int DEF_SLOTS  = 512;
    localparam int DEF_ADDR_W = 26;
    localparam int DEF_IDX_W  = 12;
    localparam int DEF_CTR_W  = 4;

endpackage

// File: rtl/cpp_index_fold.sv
module cpp_index_fold #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int N_CHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W   = N_CHUNK * IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] partial [N_CHUNK];

    assign padded     = PAD_W'(addr);
    assign partial[0] = padded[IDX_W-1:0];

    for (genvar g = 1; g < N_CHUNK; g++) begin : g_fold
        assign partial[g] = partial[g-1] ^ padded[g*IDX_W +: IDX_W];
    end

    assign idx = partial[N_CHUNK-1];
endmodule

// File: rtl/cpp_line_counters.sv
module cpp_line_counters #(
    parameter int NUM_SLOTS = 512,
    parameter int CTR_W     = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SLOT_W-1:0] acc_slot,
    input  logic              acc_crit,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [SLOT_W-1:0] evict_slot,
    output logic [CTR_W-1:0]  evict_level
);
    localparam logic [CTR_W-1:0] CTR_MID = {1'b1, {(CTR_W-1){1'b0}}};
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    logic [CTR_W-1:0] ctr_q [NUM_SLOTS];
    logic [CTR_W-1:0] acc_base;
    logic             acc_hits_fill;
    logic             acc_hits_evict;

    function automatic logic [CTR_W-1:0] sat_step(logic [CTR_W-1:0] v, logic up);
        if (up) return (v == CTR_MAX) ? v : v + 1'b1;
        else    return (v == '0)      ? v : v - 1'b1;
    endfunction

    // an access sharing its slot with a fill belongs to the new line
    assign acc_hits_fill  = acc_valid && fill_valid && (acc_slot == fill_slot);
    assign acc_hits_evict = acc_valid && (acc_slot == evict_slot) &&
                            !(fill_valid && (fill_slot == evict_slot));
    assign acc_base       = acc_hits_fill ? CTR_MID : ctr_q[acc_slot];

    always_comb begin
        evict_level = ctr_q[evict_slot];
        if (acc_hits_evict) begin
            evict_level = sat_step(ctr_q[evict_slot], acc_crit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) ctr_q[i] <= CTR_MID;
        end else begin
            if (fill_valid) ctr_q[fill_slot] <= CTR_MID;
            if (acc_valid)  ctr_q[acc_slot]  <= sat_step(acc_base, acc_crit);
        end
    end
endmodule

// File: rtl/cpp_place_table.sv
module cpp_place_table
    import cpp_pkg::*;
#(
    parameter int IDX_W     = 12,
    localparam int ENTRIES  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output bank_e            rd_bank
);
    logic [ENTRIES-1:0] bits_q;
    logic               rd_next;

    // write-before-read on an index collision
    assign rd_next = (wr_en && (wr_idx == rd_idx)) ? wr_bit : bits_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q   <= '1;
            rd_valid <= 1'b0;
            rd_bank  <= BANK_COLD;
        end else begin
            if (wr_en) bits_q[wr_idx] <= wr_bit;
            rd_valid <= rd_en;
            if (rd_en) rd_bank <= bank_e'(rd_next);
        end
    end
endmodule

// File: rtl/crit_place_predictor.sv
module crit_place_predictor
    import cpp_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int IDX_W     = DEF_IDX_W,
    parameter int CTR_W     = DEF_CTR_W,
    parameter int THRESH    = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SLOT_W-1:0] acc_slot,
    input  logic              acc_crit,
    input  logic              evict_valid,
    input  logic [SLOT_W-1:0] evict_slot,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              evict_rsp_valid,
    output logic              evict_rsp_crit,
    output logic              fill_rsp_valid,
    output logic              fill_rsp_hot
);
    localparam logic [CTR_W-1:0] THR_L = CTR_W'(THRESH);

    logic [CTR_W-1:0] evict_level;
    logic             evict_is_crit;
    logic [IDX_W-1:0] evict_idx;
    logic [IDX_W-1:0] fill_idx;
    bank_e            fill_bank;

    cpp_line_counters #(
        .NUM_SLOTS (NUM_SLOTS),
        .CTR_W     (CTR_W)
    ) u_ctrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_slot    (acc_slot),
        .acc_crit    (acc_crit),
        .fill_valid  (fill_valid),
        .fill_slot   (fill_slot),
        .evict_slot  (evict_slot),
        .evict_level (evict_level)
    );

    cpp_index_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold_ev (
        .addr (evict_addr),
        .idx  (evict_idx)
    );

    cpp_index_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold_fi (
        .addr (fill_addr),
        .idx  (fill_idx)
    );

    assign evict_is_crit = (evict_level >= THR_L);

    cpp_place_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (evict_valid),
        .wr_idx   (evict_idx),
        .wr_bit   (evict_is_crit),
        .rd_en    (fill_valid),
        .rd_idx   (fill_idx),
        .rd_valid (fill_rsp_valid),
        .rd_bank  (fill_bank)
    );

    assign fill_rsp_hot = (fill_bank == BANK_HOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_rsp_valid <= 1'b0;
            evict_rsp_crit  <= 1'b0;
        end else begin
            evict_rsp_valid <= evict_valid;
            if (evict_valid) evict_rsp_crit <= evict_is_crit;
        end
    end
endmodule

// File: rtl/cpp_checker.sv
module cpp_checker #(
    parameter int SLOT_W = 9,
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [SLOT_W-1:0] acc_slot,
    input logic              evict_valid,
    input logic [SLOT_W-1:0] evict_slot,
    input logic [ADDR_W-1:0] evict_addr,
    input logic              fill_valid,
    input logic [SLOT_W-1:0] fill_slot,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              evict_rsp_valid,
    input logic              evict_rsp_crit,
    input logic              fill_rsp_valid,
    input logic              fill_rsp_hot
);
    a_r11_fill_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fill_rsp_valid == $past(fill_valid)));

    a_r11_evict_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evict_rsp_valid == $past(evict_valid)));

    a_r8_same_cycle_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && fill_valid && (evict_addr == fill_addr))
        |=> (fill_rsp_hot == evict_rsp_crit));

    a_r5_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !evict_valid && $past(evict_valid) && ($past(evict_addr) == fill_addr))
        |=> (fill_rsp_hot == $past(evict_rsp_crit)));

    a_r1_fresh_line_critical: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && $past(fill_valid) && ($past(fill_slot) == evict_slot) &&
         !($past(acc_valid) && ($past(acc_slot) == evict_slot)) &&
         !(acc_valid && (acc_slot == evict_slot)))
        |=> evict_rsp_crit);
endmodule

bind crit_place_predictor cpp_checker #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_slot        (acc_slot),
    .evict_valid     (evict_valid),
    .evict_slot      (evict_slot),
    .evict_addr      (evict_addr),
    .fill_valid      (fill_valid),
    .fill_slot       (fill_slot),
    .fill_addr       (fill_addr),
    .evict_rsp_valid (evict_rsp_valid),
    .evict_rsp_crit  (evict_rsp_crit),
    .fill_rsp_valid  (fill_rsp_valid),
    .fill_rsp_hot    (fill_rsp_hot)
);

// File: tb/tb_crit_place_predictor.sv
`timescale 1ns/1ps
module tb_crit_place_predictor;
    localparam int SLOTS  = 512;
    localparam int SW     = 9;
    localparam int AW     = 26;
    localparam int IW     = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_valid, acc_crit, evict_valid, fill_valid;
    logic [SW-1:0] acc_slot, evict_slot, fill_slot;
    logic [AW-1:0] evict_addr, fill_addr;
    logic          evict_rsp_valid, evict_rsp_crit, fill_rsp_valid, fill_rsp_hot;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_ctr [SLOTS];
    bit m_tbl [1 << IW];
    bit exp_ev_v, exp_ev_c, exp_fi_v, exp_fi_h;

    always #2.5 clk = ~clk;

    crit_place_predictor dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_slot(acc_slot), .acc_crit(acc_crit),
        .evict_valid(evict_valid), .evict_slot(evict_slot), .evict_addr(evict_addr),
        .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_addr(fill_addr),
        .evict_rsp_valid(evict_rsp_valid), .evict_rsp_crit(evict_rsp_crit),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_hot(fill_rsp_hot)
    );

    function automatic int fold(logic [AW-1:0] a);
        logic [35:0] p = 36'(a);
        return int'(p[11:0] ^ p[23:12] ^ p[35:24]);
    endfunction

    function automatic int sat(int v, bit up);
        if (up) return (v >= 15) ? 15 : v + 1;
        return (v <= 0) ? 0 : v - 1;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(string tag, bit av, int as, bit ac, bit ev, int es,
                         logic [AW-1:0] ea, bit fv, int fs, logic [AW-1:0] fa);
        int  lvl;
        int  base;
        bit  crit = 1'b0;
        acc_valid = av; acc_slot = SW'(as); acc_crit = ac;
        evict_valid = ev; evict_slot = SW'(es); evict_addr = ea;
        fill_valid = fv; fill_slot = SW'(fs); fill_addr = fa;
        exp_ev_v = ev; exp_fi_v = fv;
        if (ev) begin
            lvl = m_ctr[es];
            if (av && as == es && !(fv && fs == es)) lvl = sat(lvl, ac);
            crit = (lvl >= 8);
            exp_ev_c = crit;
        end
        if (fv) exp_fi_h = (ev && fold(ea) == fold(fa)) ? crit : m_tbl[fold(fa)];
        if (ev) m_tbl[fold(ea)] = crit;
        if (fv) m_ctr[fs] = 8;
        if (av) begin
            base = (fv && fs == as) ? 8 : m_ctr[as];
            m_ctr[as] = sat(base, ac);
        end
        @(negedge clk);
        check_bit({tag, " R11 evict valid"}, evict_rsp_valid, exp_ev_v);
        check_bit({tag, " R11 fill valid"},  fill_rsp_valid,  exp_fi_v);
        if (exp_ev_v) check_bit({tag, " R4 evict class"}, evict_rsp_crit, exp_ev_c);
        if (exp_fi_v) check_bit({tag, " R5 fill bank"},   fill_rsp_hot,   exp_fi_h);
    endtask

    task automatic idle();
        drive("idle", 0, 0, 0, 0, 0, '0, 0, 0, '0);
    endtask

    task automatic fill(string tag, int s, logic [AW-1:0] a);
        drive(tag, 0, 0, 0, 0, 0, '0, 1, s, a);
    endtask

    task automatic evict(string tag, int s, logic [AW-1:0] a);
        drive(tag, 0, 0, 0, 1, s, a, 0, 0, '0);
    endtask

    task automatic touch(string tag, int s, bit c, int n);
        for (int i = 0; i < n; i++) drive(tag, 1, s, c, 0, 0, '0, 0, 0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pool [16];
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        for (int i = 0; i < SLOTS; i++) m_ctr[i] = 8;
        for (int i = 0; i < (1 << IW); i++) m_tbl[i] = 1'b1;
        acc_valid = 0; acc_slot = '0; acc_crit = 0;
        evict_valid = 0; evict_slot = '0; evict_addr = '0;
        fill_valid = 0; fill_slot = '0; fill_addr = '0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        check_bit("reset evict_rsp_valid", evict_rsp_valid, 1'b0);
        check_bit("reset fill_rsp_valid",  fill_rsp_valid,  1'b0);
        rst_n = 1;

        // R6: unseen addresses go to the hot bank
        fill("R6 unseen", 0, 26'h0000011);
        check_bit("R6 literal", fill_rsp_hot, 1'b1);
        fill("R6 unseen high", 9, 26'h3ABCDEF);
        check_bit("R6 literal high", fill_rsp_hot, 1'b1);

        // R1 / R4: fresh counter 8 sits on the threshold
        fill("R1 fill", 1, 26'h0000012);
        evict("R1 evict", 1, 26'h0000012);
        check_bit("R1 midpoint critical", evict_rsp_crit, 1'b1);

        // R2 / R4 / R5: one non-critical access drops to 7
        fill("R2 fill", 2, 26'h0000013);
        touch("R2 dec", 2, 0, 1);
        evict("R2 evict", 2, 26'h0000013);
        check_bit("R2 below threshold", evict_rsp_crit, 1'b0);
        fill("R5 refill", 3, 26'h0000013);
        check_bit("R5 cold placement", fill_rsp_hot, 1'b0);

        // R7: alias with equal fold shares the entry
        fill("R7 alias", 3, 26'h0000013 ^ 26'h1000001);
        check_bit("R7 alias cold", fill_rsp_hot, 1'b0);
        fill("R7 neighbour", 3, 26'h0000014);
        check_bit("R7 neighbour hot", fill_rsp_hot, 1'b1);

        // R3: saturation at the top
        fill("R3 fill hi", 4, 26'h0000015);
        touch("R3 up", 4, 1, 12);
        touch("R3 down", 4, 0, 8);
        evict("R3 evict hi", 4, 26'h0000015);
        check_bit("R3 sat at 15", evict_rsp_crit, 1'b0);

        // R3: saturation at the bottom
        fill("R3 fill lo", 5, 26'h0000016);
        touch("R3 down", 5, 0, 12);
        touch("R3 up", 5, 1, 8);
        evict("R3 evict lo", 5, 26'h0000016);
        check_bit("R3 sat at 0", evict_rsp_crit, 1'b1);

        // R9: access and fill on one slot in the same cycle
        fill("R9 old line", 6, 26'h0000017);
        touch("R9 raise", 6, 1, 5);
        drive("R9 fill+acc", 1, 6, 0, 0, 0, '0, 1, 6, 26'h0000018);
        evict("R9 evict", 6, 26'h0000018);
        check_bit("R9 access on new line", evict_rsp_crit, 1'b0);

        // R10: access and eviction on one slot in the same cycle
        fill("R10 fill", 7, 26'h0000019);
        drive("R10 acc+evict", 1, 7, 0, 1, 7, 26'h0000019, 0, 0, '0);
        check_bit("R10 access counted", evict_rsp_crit, 1'b0);
        // R10: eviction sharing its slot with a fill sees the old counter
        touch("R10 dec", 8, 0, 2);
        drive("R10 evict+fill", 0, 0, 0, 1, 8, 26'h000001A, 1, 8, 26'h000001B);
        check_bit("R10 old counter", evict_rsp_crit, 1'b0);
        evict("R10 fresh", 8, 26'h000001B);
        check_bit("R10 fill reset", evict_rsp_crit, 1'b1);

        // R8: eviction and fill on one index in the same cycle
        fill("R8 fill", 0, 26'h000001C);
        touch("R8 dec", 0, 0, 1);
        drive("R8 collide", 0, 0, 0, 1, 0, 26'h000001C, 1, 0, 26'h000001C);
        check_bit("R8 forwarded cold", fill_rsp_hot, 1'b0);

        idle();

        // random phase over a small slot range and an aliasing address pool
        for (int i = 0; i < 8; i++) begin
            pool[i]     = AW'($urandom);
            pool[i + 8] = pool[i] ^ {2'b00, 12'(i * 37 + 5), 12'(i * 37 + 5)};
        end
        for (int n = 0; n < 4000; n++) begin
            drive("R5/R8/R9/R10 random",
                  ($urandom % 2) == 0, $urandom % 8, $urandom % 2,
                  ($urandom % 3) == 0, $urandom % 8, pool[$urandom % 16],
                  ($urandom % 3) == 0, $urandom % 8, pool[$urandom % 16]);
        end
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule